// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block watches the command stream that a DRAM scheduler issues. It tells the scheduler, one bank at a time and every clock cycle, whether an ACTIVATE, a READ/WRITE, a READ/WRITE with auto-precharge, or a PRECHARGE would be legal in that cycle. The block keeps its own countdown counters for each bank, plus a shared rolling window that limits how many activates may fall in a short span across all banks. All timing values come from programmable inputs and are counted in clock cycles.

The scheduler reads the per-bank flags before it picks a command. It then presents that command on `cmd_*` for one cycle, and the tracker updates its counters at that clock edge. When a row has stayed open for the maximum allowed time, a per-bank request asks the scheduler to close it. A command issued while its flag is low sets a sticky violation bit. A zero auto-precharge recovery setting raises a configuration error.

Top module: `dram_bank_timing`

## Requirements
- R1: Two ACTIVATEs (cmd_type 0) to the same bank must be at least `t_rc` cycles apart. After an ACTIVATE sampled at edge k, `act_ok` for that bank is low until the cycle after edge k+t_rc-1. ACTIVATE is also refused while the bank is open.
- R2: READ (cmd_type 1) and WRITE (cmd_type 2) to a bank become legal (`rw_ok` high) `t_rcd` cycles after that bank's ACTIVATE, and only while the bank is open.
- R3: PRECHARGE (cmd_type 3) becomes legal (`pre_ok` high) `t_ras_min` cycles after the bank's ACTIVATE, and only while the bank is open. A PRECHARGE closes the bank.
- R4: A READ/WRITE with auto-precharge (`cmd_ap`=1) is legal (`rwap_ok`) only when `rw_ok` is high and either `t_ras_min` has elapsed or `ras_lockout` is 1. `ras_lockout` acts on `rwap_ok` in the same cycle.
- R5: A WRITE with auto-precharge closes the bank and holds `act_ok` low for `t_dal` cycles after it. A READ with auto-precharge also closes the bank.
- R6: At most `FAW_SLOTS` (default 4) ACTIVATEs, counted over all banks, may fall in any `t_faw`-cycle window. When the window is full, `act_ok` is low for every bank.
- R7: `force_pre` for a bank goes high once the bank's row has been open for `t_ras_max` cycles. It stays high until that row is closed.
- R8: `cfg_err` is high whenever `t_dal` is zero.
- R9: A command whose legality flag was low in the cycle it was issued sets `violation`. `violation` then stays high until reset. A PRECHARGE to a closed bank also counts as such a command.
- R10: A synchronous active-high `rst` clears every counter. After reset, every bank reports `act_ok`=1, `rw_ok`=`pre_ok`=`rwap_ok`=`force_pre`=0, and `violation`=0.
- R11: Each bank's counters are independent, so commands to one bank do not change another bank's flags apart from the shared activate window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | input | BANK_W (3) | Target bank |
| cmd_ap | input | 1 | Auto-precharge on READ/WRITE |
| t_rc | input | RC_W (5) | Same-bank activate spacing |
| t_rcd | input | RCD_W (8) | Activate to READ/WRITE delay |
| t_ras_min | input | RAS_W (8) | Minimum row-open time |
| t_ras_max | input | RASMAX_W (16) | Maximum row-open time |
| t_dal | input | DAL_W (4) | Write-with-auto-precharge recovery, precharge included |
| t_faw | input | FAW_W (5) | Rolling activate window length |
| ras_lockout | input | 1 | Allow auto-precharge before minimum row time |
| act_ok | output | NUM_BANKS (8) | ACTIVATE legal, per bank |
| rw_ok | output | NUM_BANKS (8) | READ/WRITE legal, per bank |
| rwap_ok | output | NUM_BANKS (8) | READ/WRITE with auto-precharge legal, per bank |
| pre_ok | output | NUM_BANKS (8) | PRECHARGE legal, per bank |
| force_pre | output | NUM_BANKS (8) | Row open too long, per bank |
| cfg_err | output | 1 | Zero recovery time programmed |
| violation | output | 1 | Sticky illegal-command flag |

## Verification
Filling the rolling activate window is the hardest case to reach. It needs four ACTIVATEs to different banks on back-to-back edges, each with its own `act_ok` still high, before a fifth bank can be shown blocked while it is otherwise idle. The bench issues these four commands with no gap, then counts idle cycles until the oldest entry expires. Reaching `force_pre` without a long run needs a small `t_ras_max` together with a larger `t_ras_min`. That combination also shows the close request staying high while PRECHARGE is still illegal.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_PRE = 2'd3
   } dbt_cmd_e;
endpackage

// File: rtl/dbt_act_window.sv
// Rolling activate window: a pool of countdown slots shared by all banks.
module dbt_act_window #(
   parameter int SLOTS = 4,
   parameter int FAW_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_fire,
   input  logic [FAW_W-1:0] t_faw,
   output logic             room
);
   generate
      if (SLOTS == 0) begin : g_off
         assign room = 1'b1;
      end else begin : g_on
         logic [FAW_W-1:0] slot_q [SLOTS];
         logic [SLOTS-1:0] free;
         logic [SLOTS-1:0] pick;
         logic [FAW_W-1:0] load_val;

         assign load_val = (t_faw == '0) ? '0 : t_faw - 1'b1;

         always_comb begin
            for (int i = 0; i < SLOTS; i++) free[i] = (slot_q[i] == '0);
         end

         // lowest free slot takes the new activate
         always_comb begin
            pick = '0;
            for (int i = SLOTS - 1; i >= 0; i--) begin
               if (free[i]) pick = SLOTS'(1) << i;
            end
         end

         assign room = |free;

         for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
               if (rst)                          slot_q[s] <= '0;
               else if (act_fire && pick[s])     slot_q[s] <= load_val;
               else if (slot_q[s] != '0)         slot_q[s] <= slot_q[s] - 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbt_bank.sv
// Per-bank timing counters and legality flags.
module dbt_bank #(
   parameter int RC_W     = 5,
   parameter int RCD_W    = 8,
   parameter int RAS_W    = 8,
   parameter int RASMAX_W = 16,
   parameter int DAL_W    = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hit_act,
   input  logic                hit_close,
   input  logic                hit_wr_ap,
   input  logic [RC_W-1:0]     t_rc,
   input  logic [RCD_W-1:0]    t_rcd,
   input  logic [RAS_W-1:0]    t_ras_min,
   input  logic [RASMAX_W-1:0] t_ras_max,
   input  logic [DAL_W-1:0]    t_dal,
   input  logic                ras_lockout,
   input  logic                faw_room,
   output logic                act_ok,
   output logic                rw_ok,
   output logic                rwap_ok,
   output logic                pre_ok,
   output logic                force_pre
);
   localparam logic [RASMAX_W-1:0] AGE_TOP = '1;

   logic [RC_W-1:0]     rc_q;
   logic [RCD_W-1:0]    rcd_q;
   logic [RAS_W-1:0]    ras_q;
   logic [DAL_W-1:0]    dal_q;
   logic [RASMAX_W-1:0] age_q;
   logic                open_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rc_q   <= '0;
         rcd_q  <= '0;
         ras_q  <= '0;
         dal_q  <= '0;
         age_q  <= '0;
         open_q <= 1'b0;
      end else begin
         if (hit_act)            rc_q <= (t_rc == '0) ? '0 : t_rc - 1'b1;
         else if (rc_q != '0)    rc_q <= rc_q - 1'b1;

         if (hit_act)            rcd_q <= (t_rcd == '0) ? '0 : t_rcd - 1'b1;
         else if (rcd_q != '0)   rcd_q <= rcd_q - 1'b1;

         if (hit_act)            ras_q <= (t_ras_min == '0) ? '0 : t_ras_min - 1'b1;
         else if (ras_q != '0)   ras_q <= ras_q - 1'b1;

         if (hit_wr_ap)          dal_q <= (t_dal == '0) ? '0 : t_dal - 1'b1;
         else if (dal_q != '0)   dal_q <= dal_q - 1'b1;

         if (hit_act)            open_q <= 1'b1;
         else if (hit_close)     open_q <= 1'b0;

         if (hit_act)                          age_q <= RASMAX_W'(1);
         else if (open_q && age_q != AGE_TOP)  age_q <= age_q + 1'b1;
      end
   end

   assign act_ok    = !open_q && (rc_q == '0) && (dal_q == '0) && faw_room;
   assign rw_ok     = open_q && (rcd_q == '0);
   assign pre_ok    = open_q && (ras_q == '0);
   assign rwap_ok   = rw_ok && (ras_lockout || (ras_q == '0));
   assign force_pre = open_q && (age_q >= t_ras_max);
endmodule

// File: rtl/dram_bank_timing.sv
module dram_bank_timing
   import dbt_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int FAW_SLOTS = 4,
   parameter int RC_W      = 5,
   parameter int RCD_W     = 8,
   parameter int RAS_W     = 8,
   parameter int RASMAX_W  = 16,
   parameter int DAL_W     = 4,
   parameter int FAW_W     = 5,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_type,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic [RC_W-1:0]      t_rc,
   input  logic [RCD_W-1:0]     t_rcd,
   input  logic [RAS_W-1:0]     t_ras_min,
   input  logic [RASMAX_W-1:0]  t_ras_max,
   input  logic [DAL_W-1:0]     t_dal,
   input  logic [FAW_W-1:0]     t_faw,
   input  logic                 ras_lockout,
   output logic [NUM_BANKS-1:0] act_ok,
   output logic [NUM_BANKS-1:0] rw_ok,
   output logic [NUM_BANKS-1:0] rwap_ok,
   output logic [NUM_BANKS-1:0] pre_ok,
   output logic [NUM_BANKS-1:0] force_pre,
   output logic                 cfg_err,
   output logic                 violation
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (FAW_SLOTS < 0 || FAW_SLOTS > 16) begin : g_bad_slots
         $error("FAW_SLOTS out of range");
      end
      if (RC_W < 1 || RCD_W < 1 || RAS_W < 1 || RASMAX_W < 1 || DAL_W < 1 || FAW_W < 1) begin : g_bad_w
         $error("timing field widths must be positive");
      end
   endgenerate

   dbt_cmd_e kind;
   logic     is_act, is_rw, is_wr, is_pre;
   logic     legal;
   logic     viol_q;
   logic     faw_room;

   assign kind   = dbt_cmd_e'(cmd_type);
   assign is_act = cmd_valid && (kind == CMD_ACT);
   assign is_rw  = cmd_valid && (kind == CMD_RD || kind == CMD_WR);
   assign is_wr  = cmd_valid && (kind == CMD_WR);
   assign is_pre = cmd_valid && (kind == CMD_PRE);

   dbt_act_window #(.SLOTS(FAW_SLOTS), .FAW_W(FAW_W)) u_window (
      .clk      (clk),
      .rst      (rst),
      .act_fire (is_act),
      .t_faw    (t_faw),
      .room     (faw_room)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (cmd_bank == BANK_W'(b));

      dbt_bank #(
         .RC_W(RC_W), .RCD_W(RCD_W), .RAS_W(RAS_W),
         .RASMAX_W(RASMAX_W), .DAL_W(DAL_W)
      ) u_bank (
         .clk         (clk),
         .rst         (rst),
         .hit_act     (sel && is_act),
         .hit_close   (sel && (is_pre || (is_rw && cmd_ap))),
         .hit_wr_ap   (sel && is_wr && cmd_ap),
         .t_rc        (t_rc),
         .t_rcd       (t_rcd),
         .t_ras_min   (t_ras_min),
         .t_ras_max   (t_ras_max),
         .t_dal       (t_dal),
         .ras_lockout (ras_lockout),
         .faw_room    (faw_room),
         .act_ok      (act_ok[b]),
         .rw_ok       (rw_ok[b]),
         .rwap_ok     (rwap_ok[b]),
         .pre_ok      (pre_ok[b]),
         .force_pre   (force_pre[b])
      );
   end

   always_comb begin
      unique case (kind)
         CMD_ACT: legal = act_ok[cmd_bank];
         CMD_RD,
         CMD_WR:  legal = cmd_ap ? rwap_ok[cmd_bank] : rw_ok[cmd_bank];
         CMD_PRE: legal = pre_ok[cmd_bank];
         default: legal = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)                      viol_q <= 1'b0;
      else if (cmd_valid && !legal) viol_q <= 1'b1;
   end

   assign violation = viol_q;
   assign cfg_err   = (t_dal == '0);
endmodule

// File: rtl/dram_bank_timing_chk.sv
module dram_bank_timing_chk #(
   parameter int NUM_BANKS = 8,
   parameter int RCD_W     = 8,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cmd_valid,
   input logic [1:0]           cmd_type,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_ap,
   input logic [RCD_W-1:0]     t_rcd,
   input logic [NUM_BANKS-1:0] act_ok,
   input logic [NUM_BANKS-1:0] rw_ok,
   input logic [NUM_BANKS-1:0] rwap_ok,
   input logic [NUM_BANKS-1:0] pre_ok,
   input logic [NUM_BANKS-1:0] force_pre,
   input logic                 violation
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      // R1
      act_blocks_reopen_chk: assert property (@(posedge clk) disable iff (rst)
         (cmd_valid && cmd_type == 2'd0 && cmd_bank == BANK_W'(b)) |=> !act_ok[b]);
      // R2
      rcd_holds_rw_chk: assert property (@(posedge clk) disable iff (rst)
         (cmd_valid && cmd_type == 2'd0 && cmd_bank == BANK_W'(b) && t_rcd > RCD_W'(1))
         |=> !rw_ok[b]);
      // R3
      pre_closes_bank_chk: assert property (@(posedge clk) disable iff (rst)
         (cmd_valid && cmd_type == 2'd3 && cmd_bank == BANK_W'(b)) |=> (!pre_ok[b] && !rw_ok[b]));
      // R4
      rwap_within_rw_chk: assert property (@(posedge clk) disable iff (rst)
         rwap_ok[b] |-> rw_ok[b]);
      // R5
      ap_closes_bank_chk: assert property (@(posedge clk) disable iff (rst)
         (cmd_valid && cmd_type[1] != cmd_type[0] && cmd_ap && cmd_bank == BANK_W'(b))
         |=> (!rw_ok[b] && !pre_ok[b]));
      // R7
      force_means_open_chk: assert property (@(posedge clk) disable iff (rst)
         force_pre[b] |-> !act_ok[b]);
   end

   // R9
   violation_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(violation) && !$past(rst)) |-> violation);
endmodule

bind dram_bank_timing dram_bank_timing_chk #(
   .NUM_BANKS(NUM_BANKS), .RCD_W(RCD_W)
) u_chk (
   .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
   .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .t_rcd(t_rcd),
   .act_ok(act_ok), .rw_ok(rw_ok), .rwap_ok(rwap_ok), .pre_ok(pre_ok),
   .force_pre(force_pre), .violation(violation)
);

// File: tb/dram_bank_timing_test.sv
`timescale 1ns/1ps
module dram_bank_timing_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_type = 2'd0;
   logic [2:0]  cmd_bank = 3'd0;
   logic        cmd_ap = 1'b0;
   logic [4:0]  t_rc = 5'd6;
   logic [7:0]  t_rcd = 8'd3;
   logic [7:0]  t_ras_min = 8'd4;
   logic [15:0] t_ras_max = 16'd20;
   logic [3:0]  t_dal = 4'd5;
   logic [4:0]  t_faw = 5'd10;
   logic        ras_lockout = 1'b0;
   logic [7:0]  act_ok, rw_ok, rwap_ok, pre_ok, force_pre;
   logic        cfg_err, violation;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dram_bank_timing uut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .t_rc(t_rc), .t_rcd(t_rcd),
      .t_ras_min(t_ras_min), .t_ras_max(t_ras_max), .t_dal(t_dal),
      .t_faw(t_faw), .ras_lockout(ras_lockout), .act_ok(act_ok),
      .rw_ok(rw_ok), .rwap_ok(rwap_ok), .pre_ok(pre_ok),
      .force_pre(force_pre), .cfg_err(cfg_err), .violation(violation)
   );

   // {valid, type[2], bank[3], ap, chk_bank[3], act, rw, pre, rwap, force}
   localparam logic [14:0] VEC [16] = '{
      {1'b1, 2'd0, 3'd0, 1'b0, 3'd0, 5'b00000},  // ACT b0
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 5'b00000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 5'b01000},  // trcd met
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 5'b01110},  // tras_min met
      {1'b1, 2'd3, 3'd0, 1'b0, 3'd0, 5'b00000},  // PRE b0, trc not yet
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 5'b10000},  // trc met
      {1'b1, 2'd0, 3'd1, 1'b0, 3'd1, 5'b00000},  // ACT b1
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b00000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b01000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b01110},
      {1'b1, 2'd2, 3'd1, 1'b1, 3'd1, 5'b00000},  // WR+AP b1
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b00000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b00000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b00000},
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd1, 5'b10000},  // tdal met
      {1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 5'b10000}   // b0 untouched
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick(input logic v, input logic [1:0] ty, input logic [2:0] bk, input logic ap);
      cmd_valid = v; cmd_type = ty; cmd_bank = bk; cmd_ap = ap;
      @(posedge clk); #1;
      cmd_valid = 1'b0; cmd_ap = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(posedge clk); #1;
      do_reset();

      for (int i = 0; i < 16; i++) begin
         logic [14:0] v;
         logic [2:0]  cb;
         v  = VEC[i];
         cb = v[7:5];
         tick(v[14], v[13:12], v[11:9], v[8]);
         check("R1/R5/R11 act_ok", 32'(act_ok[cb]),    32'(v[4]));
         check("R2 rw_ok",         32'(rw_ok[cb]),     32'(v[3]));
         check("R3 pre_ok",        32'(pre_ok[cb]),    32'(v[2]));
         check("R4 rwap_ok",       32'(rwap_ok[cb]),   32'(v[1]));
         check("R7 force_pre",     32'(force_pre[cb]), 32'(v[0]));
      end
      check("R9 no violation after legal table", 32'(violation), 32'd0);

      // R9: READ to a closed bank is illegal and sticks
      tick(1'b1, 2'd1, 3'd7, 1'b0);
      check("R9 violation set", 32'(violation), 32'd1);
      tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R9 violation sticky", 32'(violation), 32'd1);
      check("R9 closed bank still idle", 32'(act_ok[7]), 32'd1);

      // R10: reset state
      do_reset();
      check("R10 act_ok all", 32'(act_ok), 32'hff);
      check("R10 rw_ok", 32'(rw_ok), 32'h0);
      check("R10 pre_ok", 32'(pre_ok), 32'h0);
      check("R10 rwap_ok", 32'(rwap_ok), 32'h0);
      check("R10 force_pre", 32'(force_pre), 32'h0);
      check("R10 violation", 32'(violation), 32'd0);

      // R8: zero recovery time
      check("R8 cfg_err clear", 32'(cfg_err), 32'd0);
      t_dal = 4'd0; #1;
      check("R8 cfg_err set", 32'(cfg_err), 32'd1);
      t_dal = 4'd5; #1;
      check("R8 cfg_err cleared", 32'(cfg_err), 32'd0);

      // R6: four activates fill the window
      for (int b = 0; b < 4; b++) tick(1'b1, 2'd0, 3'(b), 1'b0);
      check("R6 fifth activate blocked", 32'(act_ok[4]), 32'd0);
      check("R6 all idle banks blocked", 32'(act_ok[7:4]), 32'h0);
      for (int k = 0; k < 5; k++) tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R6 still blocked at window-1", 32'(act_ok[4]), 32'd0);
      tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R6 window expired", 32'(act_ok[4]), 32'd1);
      check("R6 no violation", 32'(violation), 32'd0);

      // R7: maximum row time
      t_ras_max = 16'd3;
      do_reset();
      tick(1'b1, 2'd0, 3'd5, 1'b0);
      check("R7 force low at start", 32'(force_pre[5]), 32'd0);
      tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R7 force low before max", 32'(force_pre[5]), 32'd0);
      tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R7 force at max", 32'(force_pre[5]), 32'd1);
      check("R3 pre still blocked", 32'(pre_ok[5]), 32'd0);
      tick(1'b0, 2'd0, 3'd0, 1'b0);
      check("R7 force held", 32'(force_pre[5]), 32'd1);
      check("R3 pre legal", 32'(pre_ok[5]), 32'd1);
      tick(1'b1, 2'd3, 3'd5, 1'b0);
      check("R7 force cleared by PRE", 32'(force_pre[5]), 32'd0);
      check("R7 no violation", 32'(violation), 32'd0);

      // R4: lockout lets auto-precharge through early
      t_ras_max = 16'd20; t_rcd = 8'd1; t_ras_min = 8'd8;
      do_reset();
      tick(1'b1, 2'd0, 3'd6, 1'b0);
      check("R2 rw immediately with trcd 1", 32'(rw_ok[6]), 32'd1);
      check("R4 rwap blocked without lockout", 32'(rwap_ok[6]), 32'd0);
      ras_lockout = 1'b1; #1;
      check("R4 rwap allowed with lockout", 32'(rwap_ok[6]), 32'd1);
      ras_lockout = 1'b0; #1;
      check("R4 rwap blocked again", 32'(rwap_ok[6]), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule